// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address after a translation lookaside buffer miss. It takes one request at a time. It picks one of two table base addresses by testing a programmable number of upper virtual address bits. It then fetches a first-level descriptor from memory. If that descriptor points to a second-level table, it fetches one more descriptor.

The result is a 40-bit physical address, a granule size code and a three-bit attribute field, or a translation fault that reports the level where it occurred. Four granules are covered: 16 MB and 1 MB blocks mapped from the first level, and 64 KB and 4 KB pages mapped from the second level.

Memory is reached through a read port with variable latency. The block issues a one-cycle request and waits for a one-cycle acknowledge that carries the descriptor word.

Top module: `table_walker`

## Requirements
- R1: With `splitBits` = N, if virtual bits [31:32-N] are all zero, the walk uses `tblBase0`, otherwise it uses `tblBase1`. N = 0 always selects `tblBase0`.
- R2: The first read address is the selected base plus virtual bits [31:20] times 4.
- R3: A first-level descriptor with bits [1:0] = 10 and bit 18 clear maps 1 MB. The physical address is {8'h00, desc[31:20], va[19:0]} and the size code is 2.
- R4: A first-level descriptor with bits [1:0] = 10 and bit 18 set maps 16 MB. The physical address is {desc[8:5], desc[23:20], desc[31:24], va[23:0]} and the size code is 3.
- R5: A first-level descriptor with bits [1:0] = 01 causes a second read at address {desc[31:10], va[19:12], 2'b00}. Walks that end at the first level make exactly one read.
- R6: A second-level descriptor with bit 1 set maps 4 KB. The physical address is {8'h00, desc[31:12], va[11:0]} and the size code is 0.
- R7: A second-level descriptor with bits [1:0] = 01 maps 64 KB. The physical address is {8'h00, desc[31:16], va[15:0]} and the size code is 1.
- R8: A first-level descriptor with bits [1:0] = 00 or 11 ends the walk with `respFault` = 1 and `respFaultLvl` = 0. Physical address, size and attributes are all zero.
- R9: A second-level descriptor with bits [1:0] = 00 ends the walk with `respFault` = 1 and `respFaultLvl` = 1. Physical address, size and attributes are all zero.
- R10: `reqReady` is high only while no walk is in progress. `memReq` is a one-cycle pulse, and a new read is issued only after the previous one has been acknowledged.
- R11: `respValid` is a one-cycle pulse. `reqReady` is high in the cycle after it.
- R12: On a successful walk, `respAttr` equals bits [4:2] of the final descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Walk request |
| reqReady | output | 1 | Walker idle, accepts request |
| reqVa | input | 32 | Virtual address to translate |
| tblBase0 | input | 32 | Table base used for low addresses |
| tblBase1 | input | 32 | Table base used otherwise |
| splitBits | input | 3 | Count N of upper bits tested for base choice |
| memReq | output | 1 | One-cycle read request |
| memAddr | output | 32 | Read byte address |
| memAck | input | 1 | Read data valid |
| memData | input | 32 | Descriptor word |
| respValid | output | 1 | Result valid pulse |
| respPa | output | 40 | Physical address |
| respSize | output | 2 | 0=4 KB, 1=64 KB, 2=1 MB, 3=16 MB |
| respAttr | output | 3 | Attribute bits of final descriptor |
| respFault | output | 1 | Translation fault |
| respFaultLvl | output | 1 | Fault level: 0 first, 1 second |

## Verification
The bench builds the walker with the default three-bit split count, so every value of N from 0 to 7 can be reached. Random split values are mixed with directed addresses that sit just below and just above the base-selection boundary. Read latency varies from zero to four wait cycles. Descriptors of every type code are drawn at random, which reaches all four granules and both fault levels. The extended-address field of the 16 MB form is driven to all ones and to all zeros.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 40;
  localparam int DESC_W = 32;
  localparam int L2B_W  = 22;

  localparam logic [1:0] SZ_4K  = 2'd0;
  localparam logic [1:0] SZ_64K = 2'd1;
  localparam logic [1:0] SZ_1M  = 2'd2;
  localparam logic [1:0] SZ_16M = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1REQ, ST_L1WAIT, ST_L2REQ, ST_L2WAIT, ST_RESP
  } walkState_t;

  typedef enum logic [1:0] {
    K_FAULT, K_TABLE, K_SECTION, K_SUPER
  } l1Kind_t;

  typedef struct packed {
    logic capReq;
    logic capL1;
    logic capL2;
    logic useL2Addr;
  } walkStrobe_t;
endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memAck,
  input  l1Kind_t     l1Kind,
  output logic        reqReady,
  output logic        memReq,
  output logic        respValid,
  output walkStrobe_t strobes
);
  walkState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (reqValid) stateNext = ST_L1REQ;
      ST_L1REQ:  stateNext = ST_L1WAIT;
      ST_L1WAIT: if (memAck) stateNext = (l1Kind == K_TABLE) ? ST_L2REQ : ST_RESP;
      ST_L2REQ:  stateNext = ST_L2WAIT;
      ST_L2WAIT: if (memAck) stateNext = ST_RESP;
      ST_RESP:   stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobes.capReq    = (state == ST_IDLE) && reqValid;
    strobes.capL1     = (state == ST_L1WAIT) && memAck;
    strobes.capL2     = (state == ST_L2WAIT) && memAck;
    strobes.useL2Addr = (state == ST_L2REQ);
  end

  assign reqReady  = (state == ST_IDLE);
  assign memReq    = (state == ST_L1REQ) || (state == ST_L2REQ);
  assign respValid = (state == ST_RESP);
endmodule

// File: rtl/walk_dpath.sv
module walk_dpath
  import walk_pkg::*;
#(
  parameter int SPLIT_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [VA_W-1:0]    reqVa,
  input  logic [VA_W-1:0]    tblBase0,
  input  logic [VA_W-1:0]    tblBase1,
  input  logic [SPLIT_W-1:0] splitBits,
  input  logic [DESC_W-1:0]  memData,
  input  walkStrobe_t        strobes,
  output l1Kind_t            l1Kind,
  output logic [VA_W-1:0]    memAddr,
  output logic [PA_W-1:0]    respPa,
  output logic [1:0]         respSize,
  output logic [2:0]         respAttr,
  output logic               respFault,
  output logic               respFaultLvl
);
  localparam logic [VA_W-1:0] ALL_ONES = '1;

  logic [VA_W-1:0]  vaQ, baseQ;
  logic [L2B_W-1:0] l2BaseQ;
  logic             useHigh;

  assign useHigh = |(reqVa & ~(ALL_ONES >> splitBits));

  always_comb begin
    case (memData[1:0])
      2'b01:   l1Kind = K_TABLE;
      2'b10:   l1Kind = memData[18] ? K_SUPER : K_SECTION;
      default: l1Kind = K_FAULT;
    endcase
  end

  assign memAddr = strobes.useL2Addr ? {l2BaseQ, vaQ[19:12], 2'b00}
                                     : baseQ + {18'd0, vaQ[31:20], 2'b00};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ <= '0; baseQ <= '0; l2BaseQ <= '0;
      respPa <= '0; respSize <= SZ_4K; respAttr <= '0;
      respFault <= 1'b0; respFaultLvl <= 1'b0;
    end else if (strobes.capReq) begin
      vaQ   <= reqVa;
      baseQ <= useHigh ? tblBase1 : tblBase0;
      respPa <= '0; respSize <= SZ_4K; respAttr <= '0;
      respFault <= 1'b0; respFaultLvl <= 1'b0;
    end else if (strobes.capL1) begin
      case (l1Kind)
        K_FAULT: begin
          respFault    <= 1'b1;
          respFaultLvl <= 1'b0;
        end
        K_TABLE: l2BaseQ <= memData[31:10];
        K_SECTION: begin
          respPa   <= {8'h00, memData[31:20], vaQ[19:0]};
          respSize <= SZ_1M;
          respAttr <= memData[4:2];
        end
        default: begin
          respPa   <= {memData[8:5], memData[23:20], memData[31:24], vaQ[23:0]};
          respSize <= SZ_16M;
          respAttr <= memData[4:2];
        end
      endcase
    end else if (strobes.capL2) begin
      if (memData[1:0] == 2'b00) begin
        respFault    <= 1'b1;
        respFaultLvl <= 1'b1;
      end else if (memData[1:0] == 2'b01) begin
        respPa   <= {8'h00, memData[31:16], vaQ[15:0]};
        respSize <= SZ_64K;
        respAttr <= memData[4:2];
      end else begin
        respPa   <= {8'h00, memData[31:12], vaQ[11:0]};
        respSize <= SZ_4K;
        respAttr <= memData[4:2];
      end
    end
  end
endmodule

// File: rtl/table_walker.sv
module table_walker
  import walk_pkg::*;
#(
  parameter int SPLIT_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [VA_W-1:0]    reqVa,
  input  logic [VA_W-1:0]    tblBase0,
  input  logic [VA_W-1:0]    tblBase1,
  input  logic [SPLIT_W-1:0] splitBits,
  output logic               memReq,
  output logic [VA_W-1:0]    memAddr,
  input  logic               memAck,
  input  logic [DESC_W-1:0]  memData,
  output logic               respValid,
  output logic [PA_W-1:0]    respPa,
  output logic [1:0]         respSize,
  output logic [2:0]         respAttr,
  output logic               respFault,
  output logic               respFaultLvl
);
  walkStrobe_t strobes;
  l1Kind_t     l1Kind;

  walk_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memAck(memAck),
    .l1Kind(l1Kind), .reqReady(reqReady), .memReq(memReq),
    .respValid(respValid), .strobes(strobes)
  );

  walk_dpath #(.SPLIT_W(SPLIT_W)) i_dpath (
    .clk(clk), .rstN(rstN), .reqVa(reqVa), .tblBase0(tblBase0),
    .tblBase1(tblBase1), .splitBits(splitBits), .memData(memData),
    .strobes(strobes), .l1Kind(l1Kind), .memAddr(memAddr),
    .respPa(respPa), .respSize(respSize), .respAttr(respAttr),
    .respFault(respFault), .respFaultLvl(respFaultLvl)
  );
endmodule

// File: rtl/walk_chk.sv
module walk_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic       memReq,
  input logic       memAck,
  input logic       respValid,
  input logic       respFault,
  input logic [1:0] respSize,
  input logic [2:0] respAttr
);
  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  // R10
  mem_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
  // R10
  mem_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !reqReady && !respValid);
  // R11
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> (!respValid && reqReady));
  // R8
  fault_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respFault) |-> (respSize == 2'd0 && respAttr == 3'd0));
endmodule

bind table_walker walk_chk i_walk_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .memReq(memReq), .memAck(memAck), .respValid(respValid),
  .respFault(respFault), .respSize(respSize), .respAttr(respAttr)
);

// File: tb/test_table_walker.sv
module test_table_walker;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN, reqValid, reqReady, memReq, memAck, respValid;
  logic        respFault, respFaultLvl;
  logic [31:0] reqVa, tblBase0, tblBase1, memAddr, memData;
  logic [2:0]  splitBits, respAttr;
  logic [39:0] respPa;
  logic [1:0]  respSize;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  table_walker i_table_walker (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic walk(logic [31:0] va, logic [31:0] b0, logic [31:0] b1,
                      logic [2:0] n, logic [31:0] d1, logic [31:0] d2, int lat);
    logic [31:0] base, a1, a2, pend;
    logic [39:0] ePa;
    logic [1:0]  eSz;
    logic [2:0]  eAt;
    logic        eFlt, eLvl, got;
    int          eReads, reads, cnt;
    string       tag;
    base = (|(va & ~(32'hFFFF_FFFF >> n))) ? b1 : b0;
    a1 = base + {18'd0, va[31:20], 2'b00};
    a2 = {d1[31:10], va[19:12], 2'b00};
    ePa = '0; eSz = 2'd0; eAt = 3'd0; eFlt = 1'b0; eLvl = 1'b0; eReads = 1;
    if (d1[1:0] == 2'b10 && !d1[18]) begin
      ePa = {8'h00, d1[31:20], va[19:0]}; eSz = 2'd2; eAt = d1[4:2]; tag = "R3";
    end else if (d1[1:0] == 2'b10) begin
      ePa = {d1[8:5], d1[23:20], d1[31:24], va[23:0]}; eSz = 2'd3; eAt = d1[4:2]; tag = "R4";
    end else if (d1[1:0] == 2'b01) begin
      eReads = 2;
      if (d2[1:0] == 2'b00) begin
        eFlt = 1'b1; eLvl = 1'b1; tag = "R9";
      end else if (d2[1:0] == 2'b01) begin
        ePa = {8'h00, d2[31:16], va[15:0]}; eSz = 2'd1; eAt = d2[4:2]; tag = "R7";
      end else begin
        ePa = {8'h00, d2[31:12], va[11:0]}; eSz = 2'd0; eAt = d2[4:2]; tag = "R6";
      end
    end else begin
      eFlt = 1'b1; eLvl = 1'b0; tag = "R8";
    end

    @(negedge clk);
    chk("R11 ready before request", reqReady, 1);
    reqVa = va; tblBase0 = b0; tblBase1 = b1; splitBits = n; reqValid = 1'b1;
    reads = 0; cnt = 0; got = 0; pend = '0;
    for (int c = 0; c < 100 && !got; c++) begin
      @(negedge clk);
      reqValid = 1'b0;
      memAck = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin memAck = 1'b1; memData = pend; end
      end
      if (respValid) begin
        got = 1;
        chk({tag, " pa"}, respPa, ePa);
        chk({tag, " size"}, respSize, eSz);
        chk({tag, " R8 R9 fault"}, respFault, eFlt);
        if (eFlt) chk({tag, " level"}, respFaultLvl, eLvl);
        else chk("R12 attr", respAttr, eAt);
        chk("R5 read count", reads, eReads);
      end else if (memReq) begin
        reads++;
        chk("R10 busy during read", reqReady, 0);
        if (reads == 1) begin chk("R1 R2 first address", memAddr, a1); pend = d1; end
        else begin chk("R5 second address", memAddr, a2); pend = d2; end
        cnt = lat + 1;
      end
    end
    memAck = 1'b0;
    if (!got) chk("R11 response seen", 0, 1);
  endtask

  function automatic logic [31:0] randDesc();
    logic [31:0] d;
    d = $urandom;
    return d;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; reqValid = 1'b0; memAck = 1'b0; memData = '0;
    reqVa = '0; tblBase0 = '0; tblBase1 = '0; splitBits = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset ready", reqReady, 1);
    chk("R10 reset memReq", memReq, 0);
    chk("R11 reset respValid", respValid, 0);
    rstN = 1'b1;

    // R1 boundary: N=0 always base 0, N=7 boundary around bit 25
    walk(32'hFFF1_2345, 32'h0001_0000, 32'h0080_0000, 3'd0, 32'h1230_0012, 32'h0, 0);
    walk(32'h01FF_FFFF, 32'h0001_0000, 32'h0080_0000, 3'd7, 32'hABC0_0016, 32'h0, 1);
    walk(32'h0200_0000, 32'h0001_0000, 32'h0080_0000, 3'd7, 32'hABC0_0016, 32'h0, 2);
    // R4 extended base all ones and all zeros
    walk(32'h89AB_CDEF, 32'h4000_0000, 32'h5000_0000, 3'd1, 32'hCDF4_01FE, 32'h0, 0);
    walk(32'h1234_5678, 32'h4000_0000, 32'h5000_0000, 3'd1, 32'h7704_0006, 32'h0, 3);
    // R8 type 00 and 11
    walk(32'h1000_0000, 32'h2000_0000, 32'h3000_0000, 3'd2, 32'hFFFF_FFFC, 32'h0, 0);
    walk(32'h1000_0000, 32'h2000_0000, 32'h3000_0000, 3'd2, 32'hFFFF_FFFF, 32'h0, 1);
    // R5 R6 R7 R9 second-level forms
    walk(32'h0034_5678, 32'h0000_4000, 32'h0, 3'd3, 32'h00AB_CC01, 32'h1234_501E, 2);
    walk(32'h0034_5678, 32'h0000_4000, 32'h0, 3'd3, 32'h00AB_CC01, 32'h9876_000D, 0);
    walk(32'h0034_5678, 32'h0000_4000, 32'h0, 3'd3, 32'h00AB_CC01, 32'h9876_00F0, 4);
    for (int i = 0; i < 400; i++) begin
      walk($urandom, {$urandom} & 32'hFFFF_C000, {$urandom} & 32'hFFFF_C000,
           3'($urandom), randDesc(), randDesc(), int'($urandom % 5));
    end
    @(negedge clk);
    chk("R11 idle at end", reqReady, 1);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule